// File: doc/BRIEF.md
# PASID-Tagged Translation Cache

This block holds recently used virtual-to-physical page translations for the read and write address paths of a memory slave port. A lookup carries a virtual page number, a process address space tag and the kind of access: read or write, privileged or not, instruction fetch or not. One clock after the lookup is accepted, the block returns hit or miss, the physical page number and a permission fault flag. The storage is fully associative, with 256 entries by default.

On a miss the block raises a fill request toward the translation agent. It keeps at most one such request in flight. The agent's answer comes back on the fill port and is written into the table. Stale translations are removed by invalidation commands. An invalidation can name a single page, a whole address space tag, or every entry.

While translation is not active, the block acts as a pass-through. Each lookup returns its own page number as the physical page, and no fill request is ever raised.

Top module: `pasid_xlat_cache`

## Requirements
- R1: While `xlat_active` is low, every accepted lookup returns `rsp_hit`=1, `rsp_fault`=0 and `rsp_ppn` equal to the presented page number, and `miss_valid` never rises.
- R2: `req_ready` is high whenever no response is held. An accepted lookup produces `rsp_valid` on the next clock. A held response keeps its value until `rsp_ready` is seen.
- R3: An entry matches a lookup when it is valid, its page equals the lookup page, and either its tag equals the lookup tag or the entry was filled with `fill_global`=1. A global entry therefore serves every tag.
- R4: Permissions are packed as bit 0 read, bit 1 write, bit 2 privileged and bit 3 execute. A read needs bit 0, a write needs bit 1, `req_priv` needs bit 2 and `req_exec` needs bit 3. A matching entry that lacks a needed bit yields `rsp_fault`=1 and `rsp_hit`=0, and raises no fill request.
- R5: A miss while translation is active raises `miss_valid`, with `miss_vpn` and `miss_pasid` held until `miss_ready`. This happens only if no fill request is outstanding. A request stays outstanding until a fill with the same page and tag arrives. Any further miss before then, including a repeat of the same page, raises nothing.
- R6: `inv_kind` selects the scope. Kind 0 clears entries with the given page whose tag matches, or that are global. Kind 1 clears non-global entries with the given tag. Kinds 2 and 3 clear every entry.
- R7: When an invalidation and a fill arrive in the same cycle and the invalidation's scope covers the filled translation, the translation is not stored. A fill outside that scope is stored normally.
- R8: A fill that matches no stored key goes to the lowest-numbered invalid slot. If all slots are valid, it goes to a round-robin pointer. The pointer starts at slot 0 after reset and advances by one after each such eviction.
- R9: A fill whose page and tag equal those of a valid entry overwrites that entry in place and evicts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_active | input | 1 | Translation active; low selects pass-through |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted |
| req_vpn | input | PG_W | Virtual page number |
| req_pasid | input | PASID_W | Address space tag |
| req_write | input | 1 | Access is a write |
| req_priv | input | 1 | Access is privileged |
| req_exec | input | 1 | Access is an instruction fetch |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_ready | input | 1 | Lookup result consumed |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_fault | output | 1 | Translation found but access forbidden |
| rsp_ppn | output | PG_W | Physical page number |
| miss_valid | output | 1 | Fill request valid |
| miss_ready | input | 1 | Fill request taken |
| miss_vpn | output | PG_W | Page to be fetched |
| miss_pasid | output | PASID_W | Tag of page to be fetched |
| fill_valid | input | 1 | Translation completion valid |
| fill_vpn | input | PG_W | Completed virtual page |
| fill_pasid | input | PASID_W | Completed tag |
| fill_ppn | input | PG_W | Completed physical page |
| fill_perm | input | 4 | Permission bits (R4 packing) |
| fill_global | input | 1 | Entry matches any tag |
| inv_valid | input | 1 | Invalidation command valid |
| inv_kind | input | 2 | Scope: 0 page, 1 tag, 2/3 all |
| inv_vpn | input | PG_W | Page to invalidate |
| inv_pasid | input | PASID_W | Tag to invalidate |

## Verification
The bench repeats a miss on the same page, and misses on a second page while a request is outstanding. A design without in-flight tracking would emit duplicate requests toward the agent. It also fills and invalidates the same page in one cycle, where a design that gave the fill priority would keep a stale translation live. Tag-scoped and page-scoped invalidations are aimed at global entries, to catch a design that clears global entries on a tag sweep or ignores them on a page sweep. Finally, eviction is driven on a full table with one hole punched in it. A design that ignored free slots would evict a live translation, and one that ignored in-place overwrite would duplicate a key.

// File: rtl/pasid_xlat_cache.sv
module pasid_xlat_cache #(
  parameter int ENTRIES  = 256,
  parameter int PG_W     = 20,
  parameter int PASID_W  = 8,
  parameter bit PASID_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xlat_active,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [PG_W-1:0]    req_vpn,
  input  logic [PASID_W-1:0] req_pasid,
  input  logic               req_write,
  input  logic               req_priv,
  input  logic               req_exec,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_hit,
  output logic               rsp_fault,
  output logic [PG_W-1:0]    rsp_ppn,
  output logic               miss_valid,
  input  logic               miss_ready,
  output logic [PG_W-1:0]    miss_vpn,
  output logic [PASID_W-1:0] miss_pasid,
  input  logic               fill_valid,
  input  logic [PG_W-1:0]    fill_vpn,
  input  logic [PASID_W-1:0] fill_pasid,
  input  logic [PG_W-1:0]    fill_ppn,
  input  logic [3:0]         fill_perm,
  input  logic               fill_global,
  input  logic               inv_valid,
  input  logic [1:0]         inv_kind,
  input  logic [PG_W-1:0]    inv_vpn,
  input  logic [PASID_W-1:0] inv_pasid
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] ent_v, ent_g;
  logic [PG_W-1:0]    ent_vpn   [ENTRIES];
  logic [PG_W-1:0]    ent_ppn   [ENTRIES];
  logic [PASID_W-1:0] ent_pasid [ENTRIES];
  logic [3:0]         ent_perm  [ENTRIES];

  logic               pend_v;
  logic [PG_W-1:0]    pend_vpn;
  logic [PASID_W-1:0] pend_pasid;
  logic [IDX_W-1:0]   rr_ptr;

  logic               look_any, dup_any, fill_we, acc, start_miss, look_flt;
  logic [PG_W-1:0]    look_ppn;
  logic [3:0]         look_perm, need;
  logic [IDX_W-1:0]   free_idx, dup_idx, victim;
  logic [ENTRIES-1:0] kill;

  function automatic logic covers(input logic [PG_W-1:0] vpn,
                                  input logic [PASID_W-1:0] tag, input logic glob);
    logic tag_eq;
    tag_eq = !PASID_EN || (tag == inv_pasid);
    case (inv_kind)
      2'd0:    covers = (vpn == inv_vpn) && (tag_eq || glob);
      2'd1:    covers = !glob && tag_eq;
      default: covers = 1'b1;
    endcase
  endfunction

  always_comb begin
    look_any  = 1'b0;
    look_ppn  = '0;
    look_perm = '0;
    dup_any   = 1'b0;
    dup_idx   = '0;
    free_idx  = '0;
    kill      = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ent_v[i] && ent_vpn[i] == req_vpn &&
          (!PASID_EN || ent_g[i] || ent_pasid[i] == req_pasid)) begin
        look_any  = 1'b1;
        look_ppn  = ent_ppn[i];
        look_perm = ent_perm[i];
      end
      if (ent_v[i] && ent_vpn[i] == fill_vpn &&
          (!PASID_EN || ent_pasid[i] == fill_pasid)) begin
        dup_any = 1'b1;
        dup_idx = IDX_W'(i);
      end
      if (!ent_v[i]) free_idx = IDX_W'(i);
      kill[i] = inv_valid && covers(ent_vpn[i], ent_pasid[i], ent_g[i]);
    end
  end

  assign need       = {req_exec, req_priv, req_write, !req_write};
  assign look_flt   = look_any && |(need & ~look_perm);
  assign victim     = dup_any ? dup_idx : (&ent_v) ? rr_ptr : free_idx;
  assign fill_we    = fill_valid && !(inv_valid && covers(fill_vpn, fill_pasid, fill_global));
  assign req_ready  = !rsp_valid || rsp_ready;
  assign acc        = req_valid && req_ready;
  assign start_miss = acc && xlat_active && !look_any && !pend_v && !miss_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v  <= '0;
      rr_ptr <= '0;
    end else begin
      ent_v <= ent_v & ~kill;
      if (fill_we) begin
        ent_v[victim] <= 1'b1;
        if (!dup_any && (&ent_v)) rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_we) begin
      ent_vpn[victim]   <= fill_vpn;
      ent_ppn[victim]   <= fill_ppn;
      ent_pasid[victim] <= fill_pasid;
      ent_perm[victim]  <= fill_perm;
      ent_g[victim]     <= fill_global;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_ppn   <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= xlat_active ? (look_any && !look_flt) : 1'b1;
      rsp_fault <= xlat_active && look_flt;
      rsp_ppn   <= xlat_active ? look_ppn : req_vpn;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v     <= 1'b0;
      pend_vpn   <= '0;
      pend_pasid <= '0;
      miss_valid <= 1'b0;
      miss_vpn   <= '0;
      miss_pasid <= '0;
    end else begin
      if (start_miss) begin
        pend_v     <= 1'b1;
        pend_vpn   <= req_vpn;
        pend_pasid <= req_pasid;
        miss_valid <= 1'b1;
        miss_vpn   <= req_vpn;
        miss_pasid <= req_pasid;
      end else begin
        if (fill_valid && pend_v && fill_vpn == pend_vpn &&
            (!PASID_EN || fill_pasid == pend_pasid))
          pend_v <= 1'b0;
        if (miss_ready) miss_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pasid_xlat_cache_chk.sv
module pasid_xlat_cache_chk #(
  parameter int PG_W    = 20,
  parameter int PASID_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               xlat_active,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic               rsp_hit,
  input logic               rsp_fault,
  input logic [PG_W-1:0]    rsp_ppn,
  input logic               miss_valid,
  input logic               miss_ready,
  input logic [PG_W-1:0]    miss_vpn,
  input logic [PASID_W-1:0] miss_pasid,
  input logic               fill_valid
);
  logic in_flight;
  always_ff @(posedge clk) begin
    if (!rst_n) in_flight <= 1'b0;
    else if (miss_valid && miss_ready) in_flight <= 1'b1;
    else if (fill_valid) in_flight <= 1'b0;
  end

  AST_ONE_CYCLE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R2
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ppn) && $stable(rsp_hit)); // R2
  AST_HIT_XOR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_fault)); // R4
  AST_BYPASS_NO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss_valid) |-> $past(xlat_active && req_valid && req_ready)); // R1
  AST_MISS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && !miss_ready |=> miss_valid && $stable(miss_vpn) && $stable(miss_pasid)); // R5
  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miss_valid) |-> !$past(in_flight)); // R5
endmodule

bind pasid_xlat_cache pasid_xlat_cache_chk #(.PG_W(PG_W), .PASID_W(PASID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .xlat_active(xlat_active), .req_valid(req_valid),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_ppn(rsp_ppn),
  .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_vpn(miss_vpn),
  .miss_pasid(miss_pasid), .fill_valid(fill_valid)
);

// File: tb/pasid_xlat_cache_tb.sv
`timescale 1ns/1ps
module pasid_xlat_cache_tb;
  localparam int PG_W = 12;
  localparam int PASID_W = 4;

  logic clk = 1'b0, rst_n = 1'b0, xlat_active = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0, req_exec = 1'b0;
  logic [PG_W-1:0] req_vpn = '0;
  logic [PASID_W-1:0] req_pasid = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_fault, miss_valid;
  logic rsp_ready = 1'b1, miss_ready = 1'b1;
  logic [PG_W-1:0] rsp_ppn, miss_vpn;
  logic [PASID_W-1:0] miss_pasid;
  logic fill_valid = 1'b0, fill_global = 1'b0;
  logic [PG_W-1:0] fill_vpn = '0, fill_ppn = '0;
  logic [PASID_W-1:0] fill_pasid = '0;
  logic [3:0] fill_perm = '0;
  logic inv_valid = 1'b0;
  logic [1:0] inv_kind = '0;
  logic [PG_W-1:0] inv_vpn = '0;
  logic [PASID_W-1:0] inv_pasid = '0;

  int checks = 0, errors = 0;
  logic o_rv, o_hit, o_flt, o_mv;
  logic [PG_W-1:0] o_ppn, o_mvpn;
  logic [PASID_W-1:0] o_mpas;

  always #10 clk = ~clk;

  pasid_xlat_cache #(.ENTRIES(4), .PG_W(PG_W), .PASID_W(PASID_W)) u_dut (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look(input int vpn, input int pas, input bit wr = 0,
                      input bit pv = 0, input bit ex = 0);
    @(negedge clk);
    req_vpn = PG_W'(vpn); req_pasid = PASID_W'(pas);
    req_write = wr; req_priv = pv; req_exec = ex; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    o_rv = rsp_valid; o_hit = rsp_hit; o_flt = rsp_fault; o_ppn = rsp_ppn;
    o_mv = miss_valid; o_mvpn = miss_vpn; o_mpas = miss_pasid;
  endtask

  task automatic drive(input bit f, input int vpn, input int pas, input int ppn,
                       input int perm, input bit g,
                       input bit iv, input int kind, input int ivpn, input int ipas);
    @(negedge clk);
    fill_valid = f; fill_vpn = PG_W'(vpn); fill_pasid = PASID_W'(pas);
    fill_ppn = PG_W'(ppn); fill_perm = 4'(perm); fill_global = g;
    inv_valid = iv; inv_kind = 2'(kind); inv_vpn = PG_W'(ivpn); inv_pasid = PASID_W'(ipas);
    @(negedge clk);
    fill_valid = 1'b0; inv_valid = 1'b0;
  endtask

  task automatic fill(input int vpn, input int pas, input int ppn, input int perm, input bit g = 0);
    drive(1, vpn, pas, ppn, perm, g, 0, 0, 0, 0);
  endtask

  task automatic inval(input int kind, input int vpn, input int pas);
    drive(0, 0, 0, 0, 0, 0, 1, kind, vpn, pas);
  endtask

  task automatic t_reset;
    check("R2 reset rsp_valid", rsp_valid, 0);
    check("R2 reset req_ready", req_ready, 1);
    check("R5 reset miss_valid", miss_valid, 0);
  endtask

  task automatic t_bypass;
    xlat_active = 1'b0;
    look('h123, 5);
    check("R2 rsp one cycle", o_rv, 1);
    check("R1 bypass hit", o_hit, 1);
    check("R1 bypass ppn", o_ppn, 'h123);
    check("R1 bypass no miss", o_mv, 0);
    look('h0ab, 2, 1, 1, 1);
    check("R1 bypass no fault", o_flt, 0);
    check("R1 bypass ppn 2", o_ppn, 'h0ab);
    check("R1 bypass no miss 2", o_mv, 0);
    xlat_active = 1'b1;
  endtask

  task automatic t_miss;
    look('h010, 1);
    check("R5 miss hit", o_hit, 0);
    check("R5 miss fault", o_flt, 0);
    check("R5 miss raised", o_mv, 1);
    check("R5 miss vpn", o_mvpn, 'h010);
    check("R5 miss pasid", o_mpas, 1);
    look('h010, 1);
    check("R5 no duplicate", o_mv, 0);
    look('h011, 1);
    check("R5 single outstanding", o_mv, 0);
    fill('h010, 1, 'hA10, 'b0011);
  endtask

  task automatic t_pasid;
    look('h010, 1);
    check("R3 tag hit", o_hit, 1);
    check("R3 tag ppn", o_ppn, 'hA10);
    look('h010, 2);
    check("R3 other tag misses", o_hit, 0);
    check("R5 new miss after fill", o_mv, 1);
    fill('h010, 2, 'hB10, 'b1111);
  endtask

  task automatic t_perm;
    look('h010, 1, 1);
    check("R4 write allowed", o_hit, 1);
    look('h010, 1, 0, 0, 1);
    check("R4 exec fault", o_flt, 1);
    check("R4 fault not hit", o_hit, 0);
    check("R4 fault no miss", o_mv, 0);
    look('h010, 1, 0, 1, 0);
    check("R4 priv fault", o_flt, 1);
    look('h010, 2, 1, 1, 1);
    check("R4 all perms hit", o_hit, 1);
  endtask

  task automatic t_global;
    fill('h020, 3, 'hC20, 'b0001, 1);
    look('h020, 9);
    check("R3 global any tag", o_hit, 1);
    check("R3 global ppn", o_ppn, 'hC20);
    look('h020, 9, 1);
    check("R4 global read-only write", o_flt, 1);
  endtask

  task automatic t_inv;
    inval(1, 0, 1);
    look('h010, 1);
    check("R6 tag inval clears", o_hit, 0);
    look('h010, 2);
    check("R6 tag inval keeps other tag", o_hit, 1);
    look('h020, 1);
    check("R6 tag inval keeps global", o_hit, 1);
    fill('h010, 1, 'hA11, 'b0011);
    inval(0, 'h020, 5);
    look('h020, 3);
    check("R6 page inval clears global", o_hit, 0);
    look('h010, 1);
    check("R6 page inval keeps other page", o_hit, 1);
    check("R6 refill ppn", o_ppn, 'hA11);
    inval(2, 0, 0);
    look('h010, 2);
    check("R6 global inval tag 2", o_hit, 0);
    look('h010, 1);
    check("R6 global inval tag 1", o_hit, 0);
  endtask

  task automatic t_replace;
    for (int i = 0; i < 4; i++) fill('h100 + i, 1, 'h200 + i, 'b0001);
    fill('h104, 1, 'h204, 'b0001);
    look('h100, 1);
    check("R8 rr evicts slot 0", o_hit, 0);
    look('h104, 1);
    check("R8 new entry ppn", o_ppn, 'h204);
    look('h101, 1);
    check("R8 slot 1 kept", o_hit, 1);
    fill('h105, 1, 'h205, 'b0001);
    look('h101, 1);
    check("R8 rr evicts slot 1", o_hit, 0);
    inval(0, 'h103, 1);
    fill('h106, 1, 'h206, 'b0001);
    look('h102, 1);
    check("R8 free slot before rr", o_hit, 1);
    look('h106, 1);
    check("R8 free slot fill ppn", o_ppn, 'h206);
  endtask

  task automatic t_overwrite;
    fill('h104, 1, 'h3AA, 'b0001);
    look('h104, 1);
    check("R9 overwrite ppn", o_ppn, 'h3AA);
    look('h102, 1);
    check("R9 no eviction 102", o_hit, 1);
    look('h105, 1);
    check("R9 no eviction 105", o_hit, 1);
  endtask

  task automatic t_race;
    inval(2, 0, 0);
    drive(1, 'h050, 4, 'h450, 'b0001, 0, 1, 0, 'h050, 4);
    look('h050, 4);
    check("R7 inval wins over fill", o_hit, 0);
    drive(1, 'h051, 4, 'h451, 'b0001, 0, 1, 0, 'h052, 4);
    look('h051, 4);
    check("R7 unrelated fill kept", o_hit, 1);
    check("R7 unrelated fill ppn", o_ppn, 'h451);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_bypass;
    t_miss;
    t_pasid;
    t_perm;
    t_global;
    t_inv;
    t_replace;
    t_overwrite;
    t_race;
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule